// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the control-register bank that a 32-bit CPU reaches through its move-to-coprocessor and move-from-coprocessor instructions. Each access presents a register number and an operation code, and the block decodes the two together. Four registers hold state: system control, page table base, fault status and fault address. Their values are also driven out as ports so that the memory system can use them. Register number 0 is read-only and returns either an identification word or a cache-type word, both fixed by parameters.

Writes to register number 5 and register number 6 store nothing. A write to register 5 becomes a one-cycle cache maintenance strobe on a one-hot request vector, and a write to register 6 becomes a one-cycle TLB flush strobe. For single-line cache operations the written word is presented as a line address. Any access the block does not recognise produces a one-cycle illegal-access pulse that the CPU can use to raise a trap. Such an access changes no state, and a read of this kind returns zero.

Top module: `sysctl_regs`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the four stored registers clear to zero. The same edge also clears `cache_req`, `tlb_flush` and `illegal`.
- R2: A write with operation code 0 to register number 1, 2, 3 or 4 updates the system control, page table base, fault status or fault address register respectively. The change appears on the matching output port after that clock edge.
- R3: A read with operation code 0 of register number 1 to 4 returns the stored value. A read of register number 0 returns `ID_WORD` for operation code 0 and `CTYPE_WORD` for operation code 1.
- R4: Read data is combinational from current state. A read and a write to the same register in the same cycle return the value held before the write.
- R5: A write to register number 5 sets exactly one bit of `cache_req`, chosen by the operation code: 28 sets bit 0 (invalidate both caches), 20 sets bit 1 (invalidate instruction cache), 12 sets bit 2 (invalidate data cache), 10 sets bit 3 (clean data cache), 14 sets bit 4 (flush data cache), 13 sets bit 5 (invalidate data line), 11 sets bit 6 (clean data line) and 15 sets bit 7 (flush data line).
- R6: A line operation (operation code 13, 11 or 15 on register 5) loads the write data into `line_addr` in the same cycle its strobe rises. `line_addr` holds its value otherwise.
- R7: A write to register number 6 with an operation code from 2 to 6 inclusive raises `tlb_flush`.
- R8: `cache_req` and `tlb_flush` are high only in the cycle after the write that caused them and return low when no such write follows.
- R9: A read of an unrecognised pair returns zero, and `illegal` is high in the following cycle. The recognised read pairs are those listed in R3.
- R10: An unrecognised write changes no register and raises no strobe, and `illegal` is high in the following cycle. Unrecognised writes include register number 0, register numbers 7 to 15, a non-zero operation code to registers 1 to 4, register 5 with an unlisted code, and register 6 with a code outside 2 to 6.
- R11: When `rd_en` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Move-to-coprocessor access this cycle |
| rd_en | input | 1 | Move-from-coprocessor access this cycle |
| reg_sel | input | 4 | Coprocessor register number |
| op_sel | input | 5 | Operation code |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| ctl_q | output | 32 | System control register |
| ptb_q | output | 32 | Page table base register |
| fsr_q | output | 32 | Fault status register |
| far_q | output | 32 | Fault address register |
| cache_req | output | 8 | One-hot cache maintenance strobe |
| line_addr | output | 32 | Address for single-line cache operations |
| tlb_flush | output | 1 | Whole-TLB flush strobe |
| illegal | output | 1 | Unrecognised access pulse |

## Verification
The bench sets `ID_WORD` and `CTYPE_WORD` to distinct values that differ from the defaults. This means a swapped or mis-decoded identification read cannot accidentally match. Each stored register is written with its own distinctive pattern, so a write that reaches the wrong register is visible on every port. A table walks every listed cache code, the TLB code boundaries at 1, 2, 6 and 7, and several unrecognised pairs, so each strobe bit and the illegal pulse are checked against an independently written expectation.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int          DW         = 32,
  parameter int          RW         = 4,
  parameter int          OW         = 5,
  parameter logic [31:0] ID_WORD    = 32'h4F10_0001,
  parameter logic [31:0] CTYPE_WORD = 32'h0011_2233
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [RW-1:0] reg_sel,
  input  logic [OW-1:0] op_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] ptb_q,
  output logic [DW-1:0] fsr_q,
  output logic [DW-1:0] far_q,
  output logic [7:0]    cache_req,
  output logic [DW-1:0] line_addr,
  output logic          tlb_flush,
  output logic          illegal
);
  localparam int NCOP = 8;

  logic            op0;
  logic [DW-1:0]   rd_val;
  logic            rd_ok;
  logic            wr_ok;
  logic [NCOP-1:0] cop_d;
  logic            tlb_d;
  logic            line_op;

  assign op0 = (op_sel == '0);

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b0;
    case (reg_sel)
      RW'(0): begin
        if (op_sel == OW'(0)) begin rd_val = ID_WORD;    rd_ok = 1'b1; end
        if (op_sel == OW'(1)) begin rd_val = CTYPE_WORD; rd_ok = 1'b1; end
      end
      RW'(1): if (op0) begin rd_val = ctl_q; rd_ok = 1'b1; end
      RW'(2): if (op0) begin rd_val = ptb_q; rd_ok = 1'b1; end
      RW'(3): if (op0) begin rd_val = fsr_q; rd_ok = 1'b1; end
      RW'(4): if (op0) begin rd_val = far_q; rd_ok = 1'b1; end
      default: ;
    endcase
  end

  assign rd_data = rd_en ? rd_val : '0;

  always_comb begin
    cop_d = '0;
    tlb_d = 1'b0;
    wr_ok = 1'b0;
    case (reg_sel)
      RW'(1), RW'(2), RW'(3), RW'(4): wr_ok = op0;
      RW'(5): begin
        wr_ok = 1'b1;
        case (op_sel)
          OW'(28): cop_d[0] = 1'b1;
          OW'(20): cop_d[1] = 1'b1;
          OW'(12): cop_d[2] = 1'b1;
          OW'(10): cop_d[3] = 1'b1;
          OW'(14): cop_d[4] = 1'b1;
          OW'(13): cop_d[5] = 1'b1;
          OW'(11): cop_d[6] = 1'b1;
          OW'(15): cop_d[7] = 1'b1;
          default: wr_ok = 1'b0;
        endcase
      end
      RW'(6): begin
        tlb_d = (op_sel >= OW'(2)) && (op_sel <= OW'(6));
        wr_ok = tlb_d;
      end
      default: ;
    endcase
  end

  assign line_op = |cop_d[7:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      ptb_q     <= '0;
      fsr_q     <= '0;
      far_q     <= '0;
      cache_req <= '0;
      tlb_flush <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      if (wr_en && op0 && reg_sel == RW'(1)) ctl_q <= wr_data;
      if (wr_en && op0 && reg_sel == RW'(2)) ptb_q <= wr_data;
      if (wr_en && op0 && reg_sel == RW'(3)) fsr_q <= wr_data;
      if (wr_en && op0 && reg_sel == RW'(4)) far_q <= wr_data;
      cache_req <= wr_en ? cop_d : '0;
      tlb_flush <= wr_en && tlb_d;
      illegal   <= (wr_en && !wr_ok) || (rd_en && !rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && line_op) line_addr <= wr_data;
  end

  a_r5_req_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cache_req));

  a_r8_no_strobe_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cache_req == '0 && !tlb_flush));

  a_r2_ptb_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == RW'(2) && op_sel == '0) |=> ptb_q == $past(wr_data));

  a_r10_ctl_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && reg_sel == RW'(1) && op_sel == '0) |=> $stable(ctl_q));

  a_r10_far_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && reg_sel == RW'(4) && op_sel == '0) |=> $stable(far_q));

  a_r6_line_loaded: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == RW'(5) && op_sel == OW'(13)) |=> line_addr == $past(wr_data));

  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel > RW'(4)) |-> rd_data == '0);

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0);

  a_r7_tlb_excl: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> cache_req == '0);
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  localparam logic [31:0] IDW = 32'hA5C3_0907;
  localparam logic [31:0] CTW = 32'h1D19_2192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [4:0]  op_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, ctl_q, ptb_q, fsr_q, far_q, line_addr;
  logic [7:0]  cache_req;
  logic        tlb_flush, illegal;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  sysctl_regs #(.ID_WORD(IDW), .CTYPE_WORD(CTW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .op_sel(op_sel), .wr_data(wr_data), .rd_data(rd_data), .ctl_q(ctl_q),
    .ptb_q(ptb_q), .fsr_q(fsr_q), .far_q(far_q), .cache_req(cache_req),
    .line_addr(line_addr), .tlb_flush(tlb_flush), .illegal(illegal));

  // {reg[3:0], op[4:0], cache_req[7:0], tlb, illegal}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {4'd5, 5'd28, 8'h01, 1'b0, 1'b0},
    {4'd5, 5'd20, 8'h02, 1'b0, 1'b0},
    {4'd5, 5'd12, 8'h04, 1'b0, 1'b0},
    {4'd5, 5'd10, 8'h08, 1'b0, 1'b0},
    {4'd5, 5'd14, 8'h10, 1'b0, 1'b0},
    {4'd5, 5'd13, 8'h20, 1'b0, 1'b0},
    {4'd5, 5'd11, 8'h40, 1'b0, 1'b0},
    {4'd5, 5'd15, 8'h80, 1'b0, 1'b0},
    {4'd5, 5'd0,  8'h00, 1'b0, 1'b1},
    {4'd5, 5'd31, 8'h00, 1'b0, 1'b1},
    {4'd6, 5'd2,  8'h00, 1'b1, 1'b0},
    {4'd6, 5'd4,  8'h00, 1'b1, 1'b0},
    {4'd6, 5'd6,  8'h00, 1'b1, 1'b0},
    {4'd6, 5'd1,  8'h00, 1'b0, 1'b1},
    {4'd6, 5'd7,  8'h00, 1'b0, 1'b1},
    {4'd0, 5'd0,  8'h00, 1'b0, 1'b1},
    {4'd7, 5'd0,  8'h00, 1'b0, 1'b1},
    {4'd15, 5'd3, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic done;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [3:0] r, input logic [4:0] o, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = r; op_sel = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] r, input logic [4:0] o, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = r; op_sel = o;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    done();
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    chk("R1 ctl", ctl_q, 0); chk("R1 ptb", ptb_q, 0);
    chk("R1 fsr", fsr_q, 0); chk("R1 far", far_q, 0);
    chk("R1 strobes", {cache_req, tlb_flush, illegal}, 0);
    rst = 1'b0;

    wr(4'd1, 5'd0, 32'h1111_AAAA); chk("R2 ctl", ctl_q, 32'h1111_AAAA);
    wr(4'd2, 5'd0, 32'h2222_BBBB); chk("R2 ptb", ptb_q, 32'h2222_BBBB);
    wr(4'd3, 5'd0, 32'h3333_CCCC); chk("R2 fsr", fsr_q, 32'h3333_CCCC);
    wr(4'd4, 5'd0, 32'h4444_DDDD); chk("R2 far", far_q, 32'h4444_DDDD);
    chk("R2 ctl kept", ctl_q, 32'h1111_AAAA);
    chk("R2 illegal low", {31'd0, illegal}, 0);

    rd(4'd1, 5'd0, v); chk("R3 rd ctl", v, 32'h1111_AAAA);
    rd(4'd2, 5'd0, v); chk("R3 rd ptb", v, 32'h2222_BBBB);
    rd(4'd3, 5'd0, v); chk("R3 rd fsr", v, 32'h3333_CCCC);
    rd(4'd4, 5'd0, v); chk("R3 rd far", v, 32'h4444_DDDD);
    rd(4'd0, 5'd0, v); chk("R3 rd id", v, IDW);
    rd(4'd0, 5'd1, v); chk("R3 rd ctype", v, CTW);
    chk("R3 no illegal", {31'd0, illegal}, 0);

    // R4: same-cycle read and write
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; reg_sel = 4'd3; op_sel = 5'd0; wr_data = 32'h0BAD_F00D;
    #1 chk("R4 old value", rd_data, 32'h3333_CCCC);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R4 new value", rd_data, 32'h0BAD_F00D);
    rd_en = 1'b0;

    // R11
    reg_sel = 4'd1; op_sel = 5'd0;
    #1 chk("R11 idle zero", rd_data, 0);

    // R9
    rd(4'd5, 5'd0, v); chk("R9 rd zero", v, 0);
    chk("R9 illegal", {31'd0, illegal}, 1);
    rd(4'd1, 5'd2, v); chk("R9 rd op nz", v, 0);
    chk("R9 illegal op", {31'd0, illegal}, 1);
    rd(4'd0, 5'd2, v); chk("R9 rd id bad op", v, 0);
    @(negedge clk);
    chk("R9 illegal drops", {31'd0, illegal}, 0);

    // R5 R7 R8 R10 table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:15], VEC[i][14:10], 32'h5000_0000 + i);
      chk($sformatf("R5/R7/R10 vec%0d req", i), {22'd0, cache_req, tlb_flush, illegal},
          {22'd0, VEC[i][9:0]});
      @(negedge clk);
      chk($sformatf("R8 vec%0d drop", i), {22'd0, cache_req, tlb_flush, illegal}, 0);
    end
    chk("R10 regs untouched", ctl_q ^ ptb_q ^ fsr_q ^ far_q,
        32'h1111_AAAA ^ 32'h2222_BBBB ^ 32'h0BAD_F00D ^ 32'h4444_DDDD);

    // R6
    wr(4'd5, 5'd11, 32'hCAFE_0040); chk("R6 line addr", line_addr, 32'hCAFE_0040);
    wr(4'd5, 5'd28, 32'h9999_9999); chk("R6 line hold", line_addr, 32'hCAFE_0040);

    // R10 nonzero op to stored register
    wr(4'd1, 5'd3, 32'hDEAD_BEEF);
    chk("R10 illegal", {31'd0, illegal}, 1);
    chk("R10 ctl port", ctl_q, 32'h1111_AAAA);
    rd(4'd1, 5'd0, v); chk("R10 ctl read", v, 32'h1111_AAAA);

    // R8 back-to-back
    wr(4'd6, 5'd3, 0);
    chk("R8 tlb high", {31'd0, tlb_flush}, 1);
    @(negedge clk);
    chk("R8 tlb low", {31'd0, tlb_flush}, 0);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 rerun", ctl_q | ptb_q | fsr_q | far_q, 0);
    rst = 1'b0;
    done();
  end
endmodule